// File: doc/BRIEF.md
# Legacy Keyboard Emulation Control Register

This block is one 32-bit control and status word used by a USB host controller to emulate a PS/2 keyboard controller for legacy software. Software reaches it through a simple register port at offset 100h. The block watches host I/O writes to the keyboard data port (60h) and the keyboard command port (64h). It also takes the output-buffer-full and auxiliary-output-full flags from the emulation status logic.

From these inputs it drives three outputs. Two are legacy interrupt requests, keyboard (IRQ1) and mouse (IRQ12). The third is a combined emulation interrupt that calls the emulation software. The block also watches the IRQ1 and IRQ12 lines of an external keyboard controller. It passes each line through a two-flop synchronizer, detects rising edges, and stores them in sticky flags that software clears by writing 1.

A small gate-A20 tracker sits beside the register. A D1h command on port 64h arms it. The next data byte on port 60h is compared against the stored A20 level. A match finishes the sequence without any interrupt. A mismatch wakes the emulation software.

Top module: `kbd_emul_ctrl`

## Requirements
- R1: After reset, all defined fields (bits 0, 2–8) are 0, a read at offset 100h returns 0, and `irq1_o`, `irq12_o` and `emul_irq_o` are 0.
- R2: Bits 0 (enable), 2 (char-pending), 3 (irq-enable), 4 (external-irq-enable), 5 (A20 sequence) and 8 (A20 level) are written from `reg_wdata` and read back at the same positions. Bits 31:9 always read 0. Writes to bit 1 have no effect on it.
- R3: Writes take effect only when `reg_addr` equals 100h. At any other address, `reg_rdata` is 0 and a write changes no field.
- R4: `emul_irq_o` is 1 in the same cycle whenever enable (bit 0) and char-pending (bit 2) are both 1 and `out_full` is 0.
- R5: When bit 0, bit 3 and `out_full` are all 1, `irq1_o` is 1 if `aux_out_full` is 0, and `irq12_o` is 1 if `aux_out_full` is 1. Otherwise both are 0. The two are never 1 together.
- R6: A rising edge on `ext_irq1` sets bit 6, and one on `ext_irq12` sets bit 7. The flag becomes readable at the falling edge after the third rising clock edge following the input change. A line held high does not set the flag again once it has been cleared.
- R7: Writing 1 to bit 6 or bit 7 clears that flag, and writing 0 leaves it unchanged. If a detected edge and a clearing write fall on the same clock edge, the flag ends up 1.
- R8: When bit 4 is 1 and bit 6 or bit 7 is 1, `emul_irq_o` is 1, whatever the value of bit 0.
- R9: With bit 0 set, an I/O write of D1h to port 64h sets bit 5, and an I/O write of any other value to port 64h clears it. With bit 0 clear, port writes change nothing.
- R10: With bits 0 and 5 set, an I/O write to port 60h clears bit 5. If data bit 1 differs from bit 8, `emul_irq_o` is 1 for exactly the one cycle after that write; if it matches, no interrupt is raised. A port-60h write with bit 5 clear has no effect.
- R11: Bit 1 of a read at offset 100h equals `emul_irq_o` in the same cycle.
- R12: When a port event (R9, R10) and a register write land on the same clock edge, bit 5 takes the value set by the port event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| io_wr | input | 1 | Host I/O write strobe |
| io_addr | input | 16 | Host I/O port address |
| io_wdata | input | 8 | Host I/O write data |
| out_full | input | 1 | Emulated output buffer holds a byte |
| aux_out_full | input | 1 | The pending byte belongs to the auxiliary device |
| ext_irq1 | input | 1 | Keyboard interrupt line from external controller (asynchronous) |
| ext_irq12 | input | 1 | Mouse interrupt line from external controller (asynchronous) |
| irq1_o | output | 1 | Emulated keyboard interrupt request |
| irq12_o | output | 1 | Emulated mouse interrupt request |
| emul_irq_o | output | 1 | Emulation interrupt to the emulation software |

## Verification
The IRQ outputs, the char-pending term of the emulation interrupt and read data are combinational. They are due in the same cycle as the inputs that drive them. A register write or port write appears in the fields one clock edge later. The A20 mismatch interrupt is present only during the cycle after the port-60h write edge.

External edges travel through three flops before their flag is set. The bench therefore samples at the falling edges after the first, second and third rising edges. It expects the flag only at the third.

All inputs are driven at a falling edge and all checks are taken 1 time unit after a later falling edge. The bench's model advances its state at each rising edge, using the inputs held since the previous falling edge.

// File: rtl/kbd_emul_pkg.sv
package kbd_emul_pkg;

  localparam int REG_W = 32;

  // field positions of the control word
  localparam int B_EN    = 0;
  localparam int B_EINT  = 1;
  localparam int B_CPEND = 2;
  localparam int B_IRQEN = 3;
  localparam int B_XEN   = 4;
  localparam int B_SEQ   = 5;
  localparam int B_ACT1  = 6;
  localparam int B_ACT12 = 7;
  localparam int B_A20   = 8;
  localparam int N_FIELD = 9;

  typedef struct packed {
    logic a20;
    logic act12;
    logic act1;
    logic seq;
    logic xen;
    logic irqen;
    logic cpend;
    logic en;
  } ctrl_t;

  // legacy request steering: {irq12, irq1}
  function automatic logic [1:0] route_irq(input logic en, input logic irqen,
                                           input logic obf, input logic aux);
    logic fire;
    fire = en & irqen & obf;
    return {fire & aux, fire & ~aux};
  endfunction

  // combined emulation interrupt
  function automatic logic emul_cond(input logic en, input logic cpend,
                                     input logic obf, input logic trap,
                                     input logic xen, input logic act1,
                                     input logic act12);
    return (en & cpend & ~obf) | (en & trap) | (xen & (act1 | act12));
  endfunction

  function automatic logic [REG_W-1:0] pack_word(input ctrl_t c, input logic eint);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_EN]    = c.en;
    w[B_EINT]  = eint;
    w[B_CPEND] = c.cpend;
    w[B_IRQEN] = c.irqen;
    w[B_XEN]   = c.xen;
    w[B_SEQ]   = c.seq;
    w[B_ACT1]  = c.act1;
    w[B_ACT12] = c.act12;
    w[B_A20]   = c.a20;
    return w;
  endfunction

endpackage

// File: rtl/kbd_emul_edge_sync.sv
module kbd_emul_edge_sync #(
  parameter int N_LINES     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_i,
  output logic [N_LINES-1:0] rise_o
);

  localparam int CHAIN = SYNC_STAGES + 1;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [CHAIN-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN-2:0], line_i[g]};
    end
    assign rise_o[g] = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
  end

endmodule

// File: rtl/kbd_emul_port_decode.sv
module kbd_emul_port_decode #(
  parameter int             IO_ADDR_W = 16,
  parameter logic [15:0]    DATA_PORT = 16'h0060,
  parameter logic [15:0]    CMD_PORT  = 16'h0064,
  parameter logic [7:0]     A20_CMD   = 8'hD1
) (
  input  logic                 emu_en,
  input  logic                 io_wr,
  input  logic [IO_ADDR_W-1:0] io_addr,
  input  logic [7:0]           io_wdata,
  input  logic                 seq_q,
  input  logic                 a20_q,
  output logic                 seq_set,
  output logic                 seq_clr,
  output logic                 trap_ev
);

  logic cmd_hit, data_hit;

  always_comb begin
    cmd_hit  = emu_en & io_wr & (io_addr == IO_ADDR_W'(CMD_PORT));
    data_hit = emu_en & io_wr & (io_addr == IO_ADDR_W'(DATA_PORT)) & seq_q;
    seq_set  = cmd_hit & (io_wdata == A20_CMD);
    seq_clr  = (cmd_hit & (io_wdata != A20_CMD)) | data_hit;
    trap_ev  = data_hit & (io_wdata[1] != a20_q);
  end

endmodule

// File: rtl/kbd_emul_irq_gen.sv
module kbd_emul_irq_gen
  import kbd_emul_pkg::*;
(
  input  ctrl_t ctrl,
  input  logic  trap_q,
  input  logic  out_full,
  input  logic  aux_out_full,
  output logic  irq1_o,
  output logic  irq12_o,
  output logic  emul_irq_o
);

  logic [1:0] steer;

  always_comb begin
    steer      = route_irq(ctrl.en, ctrl.irqen, out_full, aux_out_full);
    irq1_o     = steer[0];
    irq12_o    = steer[1];
    emul_irq_o = emul_cond(ctrl.en, ctrl.cpend, out_full, trap_q,
                           ctrl.xen, ctrl.act1, ctrl.act12);
  end

endmodule

// File: rtl/kbd_emul_ctrl.sv
module kbd_emul_ctrl
  import kbd_emul_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter logic [11:0] REG_OFFSET  = 12'h100,
  parameter int          IO_ADDR_W   = 16,
  parameter logic [15:0] DATA_PORT   = 16'h0060,
  parameter logic [15:0] CMD_PORT    = 16'h0064,
  parameter logic [7:0]  A20_CMD     = 8'hD1,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic                 io_wr,
  input  logic [IO_ADDR_W-1:0] io_addr,
  input  logic [7:0]           io_wdata,
  input  logic                 out_full,
  input  logic                 aux_out_full,
  input  logic                 ext_irq1,
  input  logic                 ext_irq12,
  output logic                 irq1_o,
  output logic                 irq12_o,
  output logic                 emul_irq_o
);

  ctrl_t      ctrl_q;
  logic       trap_q;
  logic       reg_hit, reg_we;
  logic [1:0] ext_rise;
  logic       seq_set, seq_clr, trap_ev;

  assign reg_hit = (reg_addr == ADDR_W'(REG_OFFSET));
  assign reg_we  = reg_wr & reg_hit;

  kbd_emul_edge_sync #(.N_LINES(2), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i ({ext_irq12, ext_irq1}),
    .rise_o (ext_rise)
  );

  kbd_emul_port_decode #(
    .IO_ADDR_W(IO_ADDR_W), .DATA_PORT(DATA_PORT),
    .CMD_PORT(CMD_PORT), .A20_CMD(A20_CMD)
  ) u_dec (
    .emu_en   (ctrl_q.en),
    .io_wr    (io_wr),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .seq_q    (ctrl_q.seq),
    .a20_q    (ctrl_q.a20),
    .seq_set  (seq_set),
    .seq_clr  (seq_clr),
    .trap_ev  (trap_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      trap_q <= 1'b0;
    end else begin
      trap_q <= trap_ev;
      if (reg_we) begin
        ctrl_q.en    <= reg_wdata[B_EN];
        ctrl_q.cpend <= reg_wdata[B_CPEND];
        ctrl_q.irqen <= reg_wdata[B_IRQEN];
        ctrl_q.xen   <= reg_wdata[B_XEN];
        ctrl_q.a20   <= reg_wdata[B_A20];
      end
      // port events outrank software on the sequence flag
      if (seq_set)      ctrl_q.seq <= 1'b1;
      else if (seq_clr) ctrl_q.seq <= 1'b0;
      else if (reg_we)  ctrl_q.seq <= reg_wdata[B_SEQ];
      // a detected edge outranks a clearing write
      if (ext_rise[0])                       ctrl_q.act1 <= 1'b1;
      else if (reg_we && reg_wdata[B_ACT1])  ctrl_q.act1 <= 1'b0;
      if (ext_rise[1])                       ctrl_q.act12 <= 1'b1;
      else if (reg_we && reg_wdata[B_ACT12]) ctrl_q.act12 <= 1'b0;
    end
  end

  kbd_emul_irq_gen u_irq (
    .ctrl         (ctrl_q),
    .trap_q       (trap_q),
    .out_full     (out_full),
    .aux_out_full (aux_out_full),
    .irq1_o       (irq1_o),
    .irq12_o      (irq12_o),
    .emul_irq_o   (emul_irq_o)
  );

  assign reg_rdata = reg_hit ? pack_word(ctrl_q, emul_irq_o) : '0;

endmodule

// File: rtl/kbd_emul_ctrl_chk.sv
module kbd_emul_ctrl_chk #(
  parameter int          ADDR_W     = 12,
  parameter logic [11:0] REG_OFFSET = 12'h100,
  parameter int          IO_ADDR_W  = 16,
  parameter logic [15:0] CMD_PORT   = 16'h0064,
  parameter logic [7:0]  A20_CMD    = 8'hD1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [31:0]          reg_wdata,
  input logic [31:0]          reg_rdata,
  input logic                 io_wr,
  input logic [IO_ADDR_W-1:0] io_addr,
  input logic [7:0]           io_wdata,
  input logic                 out_full,
  input logic                 irq1_o,
  input logic                 irq12_o,
  input logic                 emul_irq_o,
  input logic                 emu_en,
  input logic                 seq_q,
  input logic                 act1_q,
  input logic                 act12_q,
  input logic                 xen_q,
  input logic                 trap_q,
  input logic [1:0]           rise
);

  logic hit, cmd_wr;
  assign hit    = (reg_addr == ADDR_W'(REG_OFFSET));
  assign cmd_wr = io_wr && emu_en && (io_addr == IO_ADDR_W'(CMD_PORT));

  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq1_o && irq12_o)); // R5
  AST_IRQ_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq1_o || irq12_o) |-> out_full); // R5
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:9] == 23'd0); // R2
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> reg_rdata == 32'd0); // R3
  AST_EINT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> reg_rdata[1] == emul_irq_o); // R11
  AST_SEQ_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && io_wdata == A20_CMD) |=> seq_q); // R9
  AST_SEQ_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && io_wdata != A20_CMD) |=> !seq_q); // R9
  AST_TRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |=> !trap_q); // R10
  AST_EXT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (xen_q && (act1_q || act12_q)) |-> emul_irq_o); // R8
  AST_SET_WINS1: assert property (@(posedge clk) disable iff (!rst_n)
    rise[0] |=> act1_q); // R7
  AST_SET_WINS12: assert property (@(posedge clk) disable iff (!rst_n)
    rise[1] |=> act12_q); // R7
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (act1_q && !(reg_wr && hit && reg_wdata[6])) |=> act1_q); // R7

endmodule

bind kbd_emul_ctrl kbd_emul_ctrl_chk #(
  .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET), .IO_ADDR_W(IO_ADDR_W),
  .CMD_PORT(CMD_PORT), .A20_CMD(A20_CMD)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .io_wr      (io_wr),
  .io_addr    (io_addr),
  .io_wdata   (io_wdata),
  .out_full   (out_full),
  .irq1_o     (irq1_o),
  .irq12_o    (irq12_o),
  .emul_irq_o (emul_irq_o),
  .emu_en     (ctrl_q.en),
  .seq_q      (ctrl_q.seq),
  .act1_q     (ctrl_q.act1),
  .act12_q    (ctrl_q.act12),
  .xen_q      (ctrl_q.xen),
  .trap_q     (trap_q),
  .rise       (ext_rise)
);

// File: tb/kbd_emul_ctrl_tb_top.sv
module kbd_emul_ctrl_tb_top;

  localparam int          CLK_PERIOD = 10;
  localparam logic [11:0] REG_A      = 12'h100;
  localparam int          WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = REG_A;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        out_full = 1'b0, aux_out_full = 1'b0;
  logic        ext_irq1 = 1'b0, ext_irq12 = 1'b0;
  logic        irq1_o, irq12_o, emul_irq_o;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model of the control word
  bit m_en, m_cp, m_ie, m_xe, m_seq, m_a1, m_a12, m_a20, m_trap;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_emul_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .io_wr(io_wr),
    .io_addr(io_addr), .io_wdata(io_wdata), .out_full(out_full),
    .aux_out_full(aux_out_full), .ext_irq1(ext_irq1), .ext_irq12(ext_irq12),
    .irq1_o(irq1_o), .irq12_o(irq12_o), .emul_irq_o(emul_irq_o)
  );

  function automatic bit exp_emul();
    return (m_en && m_cp && !out_full) || (m_en && m_trap) || (m_xe && (m_a1 || m_a12));
  endfunction

  function automatic logic [31:0] exp_word();
    logic [31:0] w;
    w = '0;
    w[0] = m_en; w[1] = exp_emul(); w[2] = m_cp; w[3] = m_ie; w[4] = m_xe;
    w[5] = m_seq; w[6] = m_a1; w[7] = m_a12; w[8] = m_a20;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    bit e1, e12;
    e1  = m_en && m_ie && out_full && !aux_out_full;
    e12 = m_en && m_ie && out_full && aux_out_full;
    check({req, " rdata"}, reg_rdata, exp_word());
    check({req, " irq1 R5"}, {31'd0, irq1_o}, {31'd0, e1});
    check({req, " irq12 R5"}, {31'd0, irq12_o}, {31'd0, e12});
    check({req, " emul R4/R10"}, {31'd0, emul_irq_o}, {31'd0, exp_emul()});
  endtask

  // advance model using the inputs held across the rising edge
  task automatic model_edge();
    bit o_en, o_seq, o_a20, hit;
    o_en = m_en; o_seq = m_seq; o_a20 = m_a20;
    hit = reg_wr && (reg_addr == REG_A);
    m_trap = 0;
    if (hit) begin
      m_en = reg_wdata[0]; m_cp = reg_wdata[2]; m_ie = reg_wdata[3];
      m_xe = reg_wdata[4]; m_seq = reg_wdata[5]; m_a20 = reg_wdata[8];
      if (reg_wdata[6]) m_a1 = 0;
      if (reg_wdata[7]) m_a12 = 0;
    end
    if (io_wr && o_en) begin
      if (io_addr == 16'h0064) m_seq = (io_wdata == 8'hD1);
      else if (io_addr == 16'h0060 && o_seq) begin
        m_seq = 0;
        m_trap = (io_wdata[1] != o_a20);
      end
    end
  endtask

  task automatic step(input string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    reg_wr = 0; io_wr = 0; reg_addr = REG_A;
    #1 check_all(req);
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d, input string req);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step(req);
  endtask

  task automatic io_write(input logic [15:0] p, input logic [7:0] d, input string req);
    io_wr = 1; io_addr = p; io_wdata = d;
    step(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); model_edge(); @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1 check_all("R1 reset");
    check("R1 reset word", reg_rdata, 32'd0);

    // R2: all-ones write, reserved and bit 1 stay clear
    reg_write(REG_A, 32'hFFFF_FFFF & ~32'h0000_00C0, "R2 write all");
    check("R2 rsv", {23'd0, reg_rdata[8:2]} , {23'd0, 7'b1_0011_1_1});
    reg_write(REG_A, 32'h0, "R2 clear");

    // R3: write at another offset changes nothing, read there is 0
    reg_write(12'h104, 32'h0000_011D, "R3 miss write");
    reg_addr = 12'h104; #1 check("R3 miss read", reg_rdata, 32'd0);
    reg_addr = REG_A;

    // R9: disabled port write ignored
    io_write(16'h0064, 8'hD1, "R9 disabled");
    check("R9 seq stays 0", {31'd0, reg_rdata[5]}, 32'd0);

    // R10 directed: enable, A20 level 1, arm, matching data
    reg_write(REG_A, 32'h0000_0101, "R10 setup");
    io_write(16'h0064, 8'hD1, "R9 arm");
    check("R9 armed", {31'd0, reg_rdata[5]}, 32'd1);
    io_write(16'h0060, 8'h02, "R10 match");
    check("R10 match silent", {30'd0, emul_irq_o, reg_rdata[5]}, 32'd0);
    io_write(16'h0064, 8'hD1, "R9 rearm");
    io_write(16'h0060, 8'h00, "R10 mismatch");
    check("R10 pulse", {31'd0, emul_irq_o}, 32'd1);
    check("R11 mirror", {31'd0, reg_rdata[1]}, 32'd1);
    step("R10 pulse ends");
    check("R10 pulse gone", {31'd0, emul_irq_o}, 32'd0);
    io_write(16'h0060, 8'h00, "R10 unarmed");
    check("R10 unarmed no pulse", {31'd0, emul_irq_o}, 32'd0);

    // R12: port arm and software clear on the same edge
    reg_wr = 1; reg_addr = REG_A; reg_wdata = 32'h0000_0001;
    io_wr = 1; io_addr = 16'h0064; io_wdata = 8'hD1;
    step("R12 collide");
    check("R12 port wins", {31'd0, reg_rdata[5]}, 32'd1);
    reg_write(REG_A, 32'h0, "R12 cleanup");

    // random phase (R2 R4 R5 R9 R10 R11)
    for (int i = 0; i < 3000; i++) begin
      int k;
      out_full = 1'($urandom); aux_out_full = 1'($urandom);
      k = $urandom_range(0, 9);
      if (k < 3) begin
        reg_wr = 1;
        reg_addr = ($urandom_range(0, 7) == 0) ? 12'h104 : REG_A;
        reg_wdata = $urandom;
        if ($urandom_range(0, 1) == 1) reg_wdata[0] = 1;
      end else if (k < 8) begin
        io_wr = 1;
        case ($urandom_range(0, 4))
          0, 1: io_addr = 16'h0064;
          2, 3: io_addr = 16'h0060;
          default: io_addr = 16'h0061;
        endcase
        io_wdata = ($urandom_range(0, 1) == 1) ? 8'hD1 : 8'($urandom);
      end
      step("R4 R5 R9 R10 random");
    end
    reg_write(REG_A, 32'h0, "cleanup");
    out_full = 0; aux_out_full = 0;

    // R6: latency of external edge detection
    ext_irq1 = 1;
    @(posedge clk); @(negedge clk); #1 check("R6 after 1 edge", {31'd0, reg_rdata[6]}, 32'd0);
    @(posedge clk); @(negedge clk); #1 check("R6 after 2 edges", {31'd0, reg_rdata[6]}, 32'd0);
    @(posedge clk); @(negedge clk); #1 check("R6 after 3 edges", {31'd0, reg_rdata[6]}, 32'd1);
    m_a1 = 1;
    // R8: wake with enable clear
    reg_write(REG_A, 32'h0000_0010, "R8 xen only");
    check("R8 ext wake", {31'd0, emul_irq_o}, 32'd1);
    // R7: write 0 keeps flag, write 1 clears, level does not re-set
    reg_write(REG_A, 32'h0000_0000, "R7 write zero");
    check("R7 zero keeps", {31'd0, reg_rdata[6]}, 32'd1);
    reg_write(REG_A, 32'h0000_0040, "R7 clear");
    check("R7 cleared", {31'd0, reg_rdata[6]}, 32'd0);
    idle(5);
    #1 check("R6 level no reset", {31'd0, reg_rdata[6]}, 32'd0);

    // R7: edge and clear on same edge, set wins
    ext_irq12 = 1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    reg_wr = 1; reg_wdata = 32'h0000_0080;
    @(posedge clk); @(negedge clk);
    reg_wr = 0;
    #1 check("R7 set wins", {31'd0, reg_rdata[7]}, 32'd1);
    reg_write(REG_A, 32'h0000_0080, "R7 clear 12");
    check("R7 cleared 12", {31'd0, reg_rdata[7]}, 32'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule